// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core. It keeps a 13-bit program counter, so the logical program space is 8k words. Only 2k words are physically present, and the fetch address it drives is the counter's low 11 bits. Any address above 07FFh therefore lands back inside the implemented range.

In each cycle the counter does one of five things: it steps forward, it loads a jump target, it calls, it returns, or it takes an interrupt. A call or an interrupt saves the following address on an 8-entry hardware return stack. Every kind of return takes its address from that same stack. The stack is circular and raises no fault. When a push finds the stack full, the oldest entry is replaced. A pop on an empty stack still reads the slot below the pointer. The depth output shows how many entries are valid.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fetch address is 000h and the depth is 0.
- R2: The fetch address is the program counter modulo 2048, i.e. PC bits [10:0]. A target of 0805h fetches from 005h.
- R3: When no strobe is active, the PC advances by 1 each cycle and wraps from 1FFFh to 0000h.
- R4: A jump strobe loads the PC with the 13-bit target in the next cycle.
- R5: A call strobe pushes PC+1 (mod 8192), loads the target and raises the depth by one.
- R6: A return strobe loads the PC with the most recently pushed entry and lowers the depth by one. The depth does not go below 0.
- R7: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry and leaves the depth at 8. Further pops continue around the ring.
- R8: An interrupt request pushes PC+1 and loads the PC with 0004h.
- R9: Priority when several strobes coincide is interrupt, then return, then call, then jump. Exactly one action is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Interrupt vector request |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| target_i | input | 13 | Jump or call target |
| ret_i | input | 1 | Return strobe (all return variants) |
| fetch_addr_o | output | 11 | Physical fetch address |
| depth_o | output | 4 | Number of valid stack entries (0 to 8) |

## Verification
The bench uses the default parameters: a 13-bit counter, 11 physical address bits and an 8-deep stack. These values make the 1FFFh-to-0000h wrap and the fold of targets above 07FFh reachable with a single jump. With only 8 slots, nine nested calls followed by nine returns go through the overwrite of the oldest entry and a pop from an empty stack. A behavioural model built on integers is compared with the fetch address and the depth after every clock, including cycles in which several strobes collide.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    ACT_INC  = 3'd0,
    ACT_JUMP = 3'd1,
    ACT_CALL = 3'd2,
    ACT_RET  = 3'd3,
    ACT_IRQ  = 3'd4
  } act_e;
endpackage

// File: rtl/pc_act_sel.sv
module pc_act_sel
  import pc_seq_pkg::*;
(
  input  logic irq_i,
  input  logic ret_i,
  input  logic call_i,
  input  logic jump_i,
  output act_e act_o
);
  // R9: fixed priority irq > ret > call > jump
  always_comb begin
    if (irq_i)       act_o = ACT_IRQ;
    else if (ret_i)  act_o = ACT_RET;
    else if (call_i) act_o = ACT_CALL;
    else if (jump_i) act_o = ACT_JUMP;
    else             act_o = ACT_INC;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DW    = 13,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] top_o,
  output logic [CW-1:0] depth_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] top_idx;

  assign top_idx = ptr_q - PW'(1);
  assign top_o   = mem_q[top_idx];
  assign depth_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= data_i;  // full ring: overwrites oldest
      ptr_q <= ptr_q + PW'(1);
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
    end else if (pop_i) begin
      ptr_q <= top_idx;
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r5_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(data_i));
  a_r7_full_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && depth_o == CW'(DEPTH)) |=> depth_o == CW'(DEPTH));
  a_r6_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && depth_o != '0) |=> depth_o == $past(depth_o) - CW'(1));
  a_r6_pop_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && depth_o == '0) |=> depth_o == '0);
  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CW'(DEPTH));
endmodule

// File: rtl/pc_core.sv
module pc_core
  import pc_seq_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  act_e            act_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] top_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] ret_addr_o
);
  logic [PC_W-1:0] pc_q, pc_d;

  assign ret_addr_o = pc_q + PC_W'(1);  // wraps 1FFFh -> 0
  assign pc_o       = pc_q;

  always_comb begin
    unique case (act_i)
      ACT_IRQ:  pc_d = INT_VEC;
      ACT_RET:  pc_d = top_i;
      ACT_CALL,
      ACT_JUMP: pc_d = target_i;
      default:  pc_d = ret_addr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_VEC;
    else         pc_q <= pc_d;
  end

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_INC |=> pc_q == $past(pc_q) + PC_W'(1));
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_JUMP || act_i == ACT_CALL) |=> pc_q == $past(target_i));
  a_r6_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_RET |=> pc_q == $past(top_i));
  a_r8_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_IRQ |=> pc_q == INT_VEC);
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int PHYS_W = 11,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              ret_i,
  output logic [PHYS_W-1:0] fetch_addr_o,
  output logic [CW-1:0]     depth_o
);
  act_e            act;
  logic            push, pop;
  logic [PC_W-1:0] pc, ret_addr, top;

  pc_act_sel u_sel (
    .irq_i (irq_i), .ret_i (ret_i), .call_i (call_i), .jump_i (jump_i),
    .act_o (act)
  );

  assign push = (act == ACT_CALL) || (act == ACT_IRQ);
  assign pop  = (act == ACT_RET);

  ret_stack #(.DW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i (clk_i), .rst_ni (rst_ni), .push_i (push), .pop_i (pop),
    .data_i (ret_addr), .top_o (top), .depth_o (depth_o)
  );

  pc_core #(.PC_W(PC_W)) u_core (
    .clk_i (clk_i), .rst_ni (rst_ni), .act_i (act), .target_i (target_i),
    .top_i (top), .pc_o (pc), .ret_addr_o (ret_addr)
  );

  // R2: upper PC bits are dropped, folding into the physical space
  assign fetch_addr_o = pc[PHYS_W-1:0];

  a_r9_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push, pop}));
  a_r9_irq_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> fetch_addr_o == PHYS_W'(4));
endmodule

// File: tb/pc_seq_test.sv
module pc_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        irq = 0, jump = 0, call = 0, ret = 0;
  logic [12:0] target = '0;
  logic [10:0] fetch;
  logic [3:0]  depth;

  int total = 0, bad = 0;
  bit done = 0;

  int m_pc, m_ptr, m_cnt;
  int m_mem [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_seq uut (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (irq), .jump_i (jump),
    .call_i (call), .target_i (target), .ret_i (ret),
    .fetch_addr_o (fetch), .depth_o (depth)
  );

  task automatic check(string req);
    total++;
    if (fetch !== 11'(m_pc % 2048) || depth !== 4'(m_cnt)) begin
      bad++;
      $display("FAIL %s: fetch=%h depth=%0d expected fetch=%h depth=%0d",
               req, fetch, depth, m_pc % 2048, m_cnt);
    end
  endtask

  task automatic mpush(int v);
    m_mem[m_ptr] = v;
    m_ptr = (m_ptr + 1) % 8;
    if (m_cnt < 8) m_cnt++;
  endtask

  task automatic step(bit i, bit r, bit c, bit j, int t, string req);
    irq = i; ret = r; call = c; jump = j; target = 13'(t);
    @(posedge clk);
    if (i) begin mpush((m_pc + 1) % 8192); m_pc = 4; end
    else if (r) begin
      m_ptr = (m_ptr + 7) % 8; m_pc = m_mem[m_ptr];
      if (m_cnt > 0) m_cnt--;
    end
    else if (c) begin mpush((m_pc + 1) % 8192); m_pc = t; end
    else if (j) m_pc = t;
    else m_pc = (m_pc + 1) % 8192;
    @(negedge clk);
    irq = 0; ret = 0; call = 0; jump = 0;
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_ptr = 0; m_cnt = 0;
    for (int i = 0; i < 8; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    m_pc = 1;  // one free-running step after release
    check("R1 after release");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, "R3 step");
    step(0, 0, 0, 1, 13'h1FFE, "R2 R4 jump high");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R3 wrap 1FFF");
    step(0, 0, 0, 1, 13'h0805, "R2 fold 0805");
    step(0, 0, 1, 0, 13'h0123, "R5 call");
    step(0, 0, 0, 0, 0, "R3 in callee");
    step(0, 1, 0, 0, 0, "R6 return");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 13'h0100 + 16 * i, "R7 nested call");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, "R7 R6 unwind");
    step(0, 1, 0, 0, 0, "R6 empty pop");
    step(0, 0, 0, 1, 13'h1FFF, "R4 jump top");
    step(1, 0, 0, 0, 0, "R8 irq from 1FFF");
    step(0, 1, 0, 0, 0, "R8 return from irq");
    step(0, 0, 0, 1, 13'h0040, "R4 jump");
    step(1, 1, 1, 1, 13'h0300, "R9 irq wins");
    step(0, 1, 1, 1, 13'h0300, "R9 ret over call");
    step(0, 0, 1, 1, 13'h0555, "R9 call over jump");
    step(0, 1, 0, 0, 0, "R9 return after call");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule